// File: doc/BRIEF.md
# Three-Level Extended-Address Page Walker

This block turns a 32-bit linear address into a 52-bit physical address. It reads a page hierarchy that lives in memory, with 4 KiB pages. A request brings in the linear address, a control word and a base-pointer value. The walker then issues reads one at a time over a 64-bit memory read port. When the walk ends it reports one of two results: the physical address, or a not-present fault together with the level at which the walk stopped.

Bit 5 of the control word picks the format:

- **Extended format (bit 5 set).** Entries are 8 bytes, so each table holds 512 of them. A four-slot pointer table adds a third level above the directory. The base value and every entry can place the next table, or the final frame, anywhere in the 52-bit physical space.
- **Legacy format (bit 5 clear).** The walker uses two levels of 4-byte entries. All physical addresses in this format stay below 4 GiB.

Top module: `xpage_walker`

## Requirements
- R1: After synchronous reset the walker is idle. `req_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: Extended format is selected when `ctrl_reg` bit 5 is 1 at acceptance. The first read then goes to `{base_reg[51:5], lin[31:30], 3'b000}`, which is the pointer-table slot.
- R3: In extended format each further read goes to the previous entry's bits [51:12] shifted left by 12, plus an index times 8. The index is `lin[29:21]` for the directory and `lin[20:12]` for the page table. Entry bits [63:52] and [11:1] are ignored.
- R4: A successful extended walk takes exactly three reads. It returns `done_paddr = {pte[51:12], lin[11:0]}`, and this result may lie above 4 GiB.
- R5: In legacy format only two reads are made. The first goes to `{base_reg[31:12], lin[31:22], 2'b00}` and the second to `{pde[31:12], lin[21:12], 2'b00}`. Each entry is taken from `mem_rsp_data[31:0]`. The result is `{20'b0, pte[31:12], lin[11:0]}`.
- R6: Bit 0 of each entry is the present flag. If it is 0, the walk ends at once with `done_fault = 1` and no further reads. `done_level` then holds the level of the faulting table: 0 for the pointer table, 1 for the directory, 2 for the page table. Legacy walks start at level 1.
- R7: `mem_req_valid` is a one-cycle pulse. No new read is issued until `mem_rsp_valid` returns for the current one.
- R8: A request is taken only in a cycle where `req_ready` is 1. A `req_valid` that arrives during a walk is ignored: it produces no reads and no result.
- R9: `done_valid` is a one-cycle pulse. On a fault, `done_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address to translate |
| ctrl_reg | input | 32 | Control word; bit 5 selects extended format |
| base_reg | input | 64 | Base pointer of the top-level table |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (legacy entries in bits [31:0]) |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk hit a not-present entry |
| done_level | output | 2 | Level of the faulting table |
| done_paddr | output | 52 | Translated physical address |

## Verification
The assertions rely on three things about the environment:

- The memory side returns exactly one response per read, and only after the read pulse has been seen.
- `mem_rsp_valid` stays low at all other times.
- Requests are not raised while reset is held.

The bench's memory responder follows these rules. It waits at least one cycle after each read pulse, then drives a single-cycle response, and it keeps the valid line low otherwise. The stimulus includes ignored requests raised in the middle of a walk. These requests are removed before the walker can become idle again, so the only requests it accepts are the intended ones.

// File: rtl/xpw_pkg.sv
package xpw_pkg;

    localparam int LIN_W    = 32;
    localparam int PA_W     = 52;
    localparam int ENT_W    = 64;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int MODE_BIT = 5;
    localparam int FRAME_W  = PA_W - OFF_W;

    typedef enum logic [1:0] {
        LVL_PTR = 2'd0,
        LVL_DIR = 2'd1,
        LVL_PT  = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        logic             fault;
        lvl_e             level;
        logic [PA_W-1:0]  paddr;
    } result_t;

    // Index into the table at the given level, per format.
    function automatic logic [IDX_W-1:0] pick_index(
        input logic             ext,
        input lvl_e             lvl,
        input logic [LIN_W-1:0] lin
    );
        logic [IDX_W-1:0] idx;
        idx = '0;
        if (ext) begin
            case (lvl)
                LVL_PTR: idx = {8'b0, lin[31:30]};
                LVL_DIR: idx = {1'b0, lin[29:21]};
                default: idx = {1'b0, lin[20:12]};
            endcase
        end else begin
            case (lvl)
                LVL_DIR: idx = lin[31:22];
                LVL_PT:  idx = lin[21:12];
                default: idx = '0;
            endcase
        end
        return idx;
    endfunction

    // Byte base of the top table from the base-pointer register.
    function automatic logic [PA_W-1:0] root_base(
        input logic             ext,
        input logic [ENT_W-1:0] base
    );
        if (ext)
            return {base[PA_W-1:5], 5'b0};
        else
            return {{(PA_W-32){1'b0}}, base[31:OFF_W], {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/xpw_addr_gen.sv
module xpw_addr_gen
    import xpw_pkg::*;
(
    input  logic             ext,
    input  lvl_e             lvl,
    input  logic [LIN_W-1:0] lin,
    input  logic [PA_W-1:0]  tbl_base,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int WIDE_SH   = 3;
    localparam int NARROW_SH = 2;

    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  byte_off;
    logic             unused_lin;

    assign unused_lin = ^lin[OFF_W-1:0];
    assign idx        = pick_index(ext, lvl, lin);

    always_comb begin
        byte_off = '0;
        if (ext)
            byte_off[IDX_W+WIDE_SH-1:0] = {idx, {WIDE_SH{1'b0}}};
        else
            byte_off[IDX_W+NARROW_SH-1:0] = {idx, {NARROW_SH{1'b0}}};
    end

    assign entry_addr = tbl_base + byte_off;

endmodule

// File: rtl/xpw_entry_dec.sv
module xpw_entry_dec
    import xpw_pkg::*;
(
    input  logic             ext,
    input  logic [ENT_W-1:0] raw,
    output logic             present,
    output logic [PA_W-1:0]  next_base
);
    logic [ENT_W-1:0] ent;
    logic             unused_ent;

    // Legacy entries occupy the low half of the returned word.
    assign ent        = ext ? raw : {32'b0, raw[31:0]};
    assign present    = ent[0];
    assign unused_ent = ^{ent[ENT_W-1:PA_W], ent[OFF_W-1:1]};

    always_comb begin
        if (ext)
            next_base = {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        else
            next_base = {{(PA_W-32){1'b0}}, ent[31:OFF_W], {OFF_W{1'b0}}};
    end

endmodule

// File: rtl/xpw_seq.sv
module xpw_seq
    import xpw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic ext_in,
    input  logic rsp_valid,
    input  logic present,
    output logic idle,
    output logic accept,
    output logic issue,
    output logic advance,
    output logic finish,
    output logic ext_q,
    output lvl_e lvl
);
    st_e state;

    assign idle    = (state == ST_IDLE);
    assign accept  = idle && req_valid;
    assign issue   = (state == ST_ISSUE);
    assign advance = (state == ST_WAIT) && rsp_valid && present && (lvl != LVL_PT);
    assign finish  = (state == ST_WAIT) && rsp_valid && (!present || lvl == LVL_PT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            lvl   <= LVL_PTR;
            ext_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_ISSUE;
                        ext_q <= ext_in;
                        lvl   <= ext_in ? LVL_PTR : LVL_DIR;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (finish)
                        state <= ST_IDLE;
                    else if (advance) begin
                        state <= ST_ISSUE;
                        lvl   <= (lvl == LVL_PTR) ? LVL_DIR : LVL_PT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xpage_walker.sv
module xpage_walker
    import xpw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LIN_W-1:0]  req_lin,
    input  logic [31:0]       ctrl_reg,
    input  logic [ENT_W-1:0]  base_reg,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic              done_fault,
    output logic [1:0]        done_level,
    output logic [PA_W-1:0]   done_paddr
);
    logic             idle, accept, issue, advance, finish, ext_q, present;
    lvl_e             lvl;
    logic [LIN_W-1:0] lin_q;
    logic [PA_W-1:0]  tbl_base_q;
    logic [PA_W-1:0]  next_base;
    result_t          res_q;
    logic             done_q;
    logic             unused_in;

    assign unused_in = ^{ctrl_reg[31:MODE_BIT+1], ctrl_reg[MODE_BIT-1:0]};

    xpw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ext_in    (ctrl_reg[MODE_BIT]),
        .rsp_valid (mem_rsp_valid),
        .present   (present),
        .idle      (idle),
        .accept    (accept),
        .issue     (issue),
        .advance   (advance),
        .finish    (finish),
        .ext_q     (ext_q),
        .lvl       (lvl)
    );

    xpw_addr_gen u_addr (
        .ext        (ext_q),
        .lvl        (lvl),
        .lin        (lin_q),
        .tbl_base   (tbl_base_q),
        .entry_addr (mem_req_addr)
    );

    xpw_entry_dec u_dec (
        .ext       (ext_q),
        .raw       (mem_rsp_data),
        .present   (present),
        .next_base (next_base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_q      <= '0;
            tbl_base_q <= '0;
            res_q      <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                lin_q      <= req_lin;
                tbl_base_q <= root_base(ctrl_reg[MODE_BIT], base_reg);
            end
            if (advance)
                tbl_base_q <= next_base;
            if (finish) begin
                res_q.fault <= !present;
                res_q.level <= lvl;
                res_q.paddr <= present ? {next_base[PA_W-1:OFF_W], lin_q[OFF_W-1:0]} : '0;
            end
        end
    end

    assign req_ready     = idle;
    assign mem_req_valid = issue;
    assign done_valid    = done_q;
    assign done_fault    = res_q.fault;
    assign done_level    = res_q.level;
    assign done_paddr    = res_q.paddr;

endmodule

// File: rtl/xpage_walker_chk.sv
module xpage_walker_chk
    import xpw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LIN_W-1:0]  req_lin,
    input logic [31:0]       ctrl_reg,
    input logic [ENT_W-1:0]  base_reg,
    input logic              mem_req_valid,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              done_valid,
    input logic              done_fault,
    input logic [1:0]        done_level,
    input logic [PA_W-1:0]   done_paddr
);
    logic             acc;
    logic [LIN_W-1:0] cap_lin;
    logic             cap_ext;
    logic             unused_chk;

    assign acc        = req_valid && req_ready;
    assign unused_chk = ^{ctrl_reg, base_reg, req_lin};

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lin <= '0;
            cap_ext <= 1'b0;
        end else if (acc) begin
            cap_lin <= req_lin;
            cap_ext <= ctrl_reg[MODE_BIT];
        end
    end

    p_first_ptr_read_r2: assert property (@(posedge clk) disable iff (rst)
        acc && ctrl_reg[MODE_BIT] |=> mem_req_valid &&
            mem_req_addr == {$past(base_reg[PA_W-1:5]), $past(req_lin[31:30]), 3'b000});

    p_first_dir_read_r5: assert property (@(posedge clk) disable iff (rst)
        acc && !ctrl_reg[MODE_BIT] |=> mem_req_valid &&
            mem_req_addr == {20'b0, $past(base_reg[31:12]), $past(req_lin[31:22]), 2'b00});

    p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
        done_valid && !done_fault |-> done_paddr[OFF_W-1:0] == cap_lin[OFF_W-1:0]);

    p_legacy_narrow_r5: assert property (@(posedge clk) disable iff (rst)
        done_valid && !cap_ext |-> done_paddr[PA_W-1:32] == '0);

    p_legacy_level_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault && !cap_ext |-> done_level != 2'd0);

    p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault |-> done_paddr == '0);

endmodule

bind xpage_walker xpage_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .ctrl_reg      (ctrl_reg),
    .base_reg      (base_reg),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_level    (done_level),
    .done_paddr    (done_paddr)
);

// File: tb/xpage_walker_tb.sv
module xpage_walker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic [31:0] ctrl_reg = '0;
    logic [63:0] base_reg = '0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid;
    logic        done_fault;
    logic [1:0]  done_level;
    logic [51:0] done_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpage_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .ctrl_reg(ctrl_reg), .base_reg(base_reg),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault),
        .done_level(done_level), .done_paddr(done_paddr)
    );

    typedef struct { logic [51:0] addr; string tag; } rd_exp_t;
    typedef struct { logic fault; logic [1:0] level; logic [51:0] paddr; string tag; } res_exp_t;

    logic [63:0] mem [logic [51:0]];
    rd_exp_t     rd_q[$];
    res_exp_t    res_q[$];
    int          checks = 0;
    int          fails = 0;
    int          done_seen = 0;
    int          lat = 1;

    function automatic logic [63:0] rd(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // Address formulas taken from the requirements.
    function automatic logic [51:0] a_ptr(input logic [63:0] b, input logic [31:0] l);
        return {b[51:5], l[31:30], 3'b000};                  // R2
    endfunction
    function automatic logic [51:0] a_xdir(input logic [63:0] e, input logic [31:0] l);
        return {e[51:12], l[29:21], 3'b000};                 // R3
    endfunction
    function automatic logic [51:0] a_xpt(input logic [63:0] e, input logic [31:0] l);
        return {e[51:12], l[20:12], 3'b000};                 // R3
    endfunction
    function automatic logic [51:0] a_ldir(input logic [63:0] b, input logic [31:0] l);
        return {20'b0, b[31:12], l[31:22], 2'b00};           // R5
    endfunction
    function automatic logic [51:0] a_lpt(input logic [63:0] e, input logic [31:0] l);
        return {20'b0, e[31:12], l[21:12], 2'b00};           // R5
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_rd(input logic [51:0] a, input string t);
        rd_exp_t r;
        r.addr = a; r.tag = t;
        rd_q.push_back(r);
    endtask

    task automatic push_res(input logic f, input logic [1:0] lv, input logic [51:0] p, input string t);
        res_exp_t r;
        r.fault = f; r.level = lv; r.paddr = p; r.tag = t;
        res_q.push_back(r);
    endtask

    // Driver: predicts reads and result, then launches the walk.
    task automatic walk(input logic [31:0] ctl, input logic [31:0] lin,
                        input logic [63:0] base, input int latency, input int busy_pokes);
        logic [63:0] e;
        logic [51:0] a;
        int start;
        lat = latency;
        if (ctl[5]) begin
            a = a_ptr(base, lin);  push_rd(a, "R2"); e = rd(a);
            if (!e[0]) push_res(1'b1, 2'd0, '0, "R6");
            else begin
                a = a_xdir(e, lin); push_rd(a, "R3"); e = rd(a);
                if (!e[0]) push_res(1'b1, 2'd1, '0, "R6");
                else begin
                    a = a_xpt(e, lin); push_rd(a, "R3"); e = rd(a);
                    if (!e[0]) push_res(1'b1, 2'd2, '0, "R6");
                    else push_res(1'b0, 2'd2, {e[51:12], lin[11:0]}, "R4");
                end
            end
        end else begin
            a = a_ldir(base, lin); push_rd(a, "R5"); e = {32'b0, rd(a)[31:0]};
            if (!e[0]) push_res(1'b1, 2'd1, '0, "R6");
            else begin
                a = a_lpt(e, lin); push_rd(a, "R5"); e = {32'b0, rd(a)[31:0]};
                if (!e[0]) push_res(1'b1, 2'd2, '0, "R6");
                else push_res(1'b0, 2'd2, {20'b0, e[31:12], lin[11:0]}, "R5");
            end
        end
        while (!req_ready) @(negedge clk);
        start = done_seen;
        ctrl_reg = ctl; base_reg = base; req_lin = lin; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R8: pokes while busy with a different address must be ignored
        for (int i = 0; i < busy_pokes; i++) begin
            req_valid = 1'b1; req_lin = ~lin; base_reg = ~base;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (done_seen == start) @(negedge clk);
        @(negedge clk);
        chk(done_valid == 1'b0, "R9", "done pulse length", done_valid, 0);
        repeat (4) @(negedge clk);
        chk(rd_q.size() == 0 && res_q.size() == 0 && done_seen == start + 1, "R8",
            "pending or extra work after walk", rd_q.size() + res_q.size(), 0);
    endtask

    // Memory responder and read-address monitor.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                logic [51:0] a;
                a = mem_req_addr;
                if (rd_q.size() == 0)
                    chk(1'b0, "R6", "unexpected read", a, 0);
                else begin
                    rd_exp_t r;
                    r = rd_q.pop_front();
                    chk(a == r.addr, r.tag, "read address", a, r.addr);
                end
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(mem_req_valid == 1'b0, "R7", "read while outstanding", mem_req_valid, 0);
                end
                mem_rsp_data  = rd(a);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // Result monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_valid) begin
                done_seen++;
                if (res_q.size() == 0)
                    chk(1'b0, "R8", "unexpected result", done_paddr, 0);
                else begin
                    res_exp_t r;
                    r = res_q.pop_front();
                    chk(done_fault == r.fault, r.tag, "fault flag", done_fault, r.fault);
                    chk(done_paddr == r.paddr, r.tag, "physical address", done_paddr, r.paddr);
                    if (r.fault)
                        chk(done_level == r.level, "R6", "fault level", done_level, r.level);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] xb, lb, e0, e1;
        logic [31:0] l1, l4, ll;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0, "R1",
            "reset state", {req_ready, mem_req_valid, done_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0, "R1",
            "idle after reset", {req_ready, mem_req_valid, done_valid}, 3'b100);

        // Extended hierarchy with high addresses and junk in ignored bits (R2 R3 R4)
        xb = 64'hABC0_F0AB_CDEF_125F;
        l1 = 32'hC123_4567;
        e0 = 64'h8000_0007_8901_2FFF;
        mem[a_ptr(xb, l1)] = e0;
        e1 = 64'hFFF0_00FE_DCBA_9003;
        mem[a_xdir(e0, l1)] = e1;
        mem[a_xpt(e1, l1)] = 64'h7FFA_BCDE_F012_3005;
        walk(32'h0000_0020, l1, xb, 1, 0);
        walk(32'hFFFF_FFFF, l1, xb, 3, 2);

        // Extended faults at each level (R6)
        walk(32'h0000_0020, 32'h0123_4567, xb, 2, 0);
        walk(32'h0000_0020, 32'hC000_1000, xb, 1, 0);
        l4 = {l1[31:21], l1[20:12] ^ 9'h1FF, 12'h0AB};
        walk(32'h0000_0020, l4, xb, 2, 0);

        // Legacy two-level walks (R5), upper entry half is junk
        lb = 64'hFFFF_FFFF_0003_4FFF;
        ll = 32'h8765_4321;
        e0 = 64'hDEAD_BEEF_0005_6001;
        mem[a_ldir(lb, ll)] = e0;
        mem[a_lpt(e0, ll)] = 64'hDEAD_BEEF_789A_B003;
        walk(32'hFFFF_FFDF, ll, lb, 1, 0);
        walk(32'h0000_0011, ll, lb, 2, 3);
        // Legacy faults at directory and page table (R6)
        walk(32'h0000_0000, 32'h0000_0321, lb, 1, 0);
        walk(32'h0000_0000, {ll[31:22], ~ll[21:12], 12'h123}, lb, 1, 0);

        // Same linear address as an extended walk but in legacy format
        walk(32'h0000_0000, l1, xb, 1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule